// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a read-only master for a three-wire serial EEPROM. The EEPROM has a clock pin, a chip select pin, a data input pin and a data output pin. A one-cycle start pulse comes with a 6-bit word address. The block then runs a complete read frame on the EEPROM pins. It raises chip select and shifts out a 3-bit read opcode and the address. It clocks sixteen data bits back from the device, then closes the frame with chip select low and one extra clock pulse. At the end it presents the 16-bit word with a one-cycle done strobe.

The serial timing is set by four parameters, each a count of system clocks:
- the data setup time before a rising clock edge,
- the clock high time,
- the clock low time,
- the data hold time.

The integrator picks these counts so that each clock level lasts at least 8.38 µs and setup and hold each last at least 0.4 µs at the system clock rate in use. The defaults are small values suited to simulation. While a frame runs, the block holds busy high and ignores any further start. The result register keeps the last word read until the next read completes.

Top module: `ee_word_reader`

## Requirements
- R1: `ee_cs` goes high in the cycle after an accepted start, before any rising edge of `ee_sk`. It stays high through the last data-bit clock and is low whenever no frame is running.
- R2: The outgoing bits on `ee_di` are the opcode 3'b110 followed by the 6-bit address, nine bits in all, each sent MSB first. Each bit is held for SETUP_CYC cycles with `ee_sk` low, then HIGH_CYC cycles with `ee_sk` high, then LOW_CYC cycles with `ee_sk` low.
- R3: After the ninth outgoing bit, `ee_di` is low and `ee_sk` stays low for HOLD_CYC more cycles before the first receive clock.
- R4: In the whole frame, every high level of `ee_sk` lasts exactly HIGH_CYC cycles and every low level between pulses lasts at least LOW_CYC cycles. `ee_di` never changes while `ee_sk` is high.
- R5: Sixteen receive pulses follow, each HIGH_CYC cycles high and then LOW_CYC cycles low. `ee_do` is sampled in the last high cycle of each pulse, and the first bit sampled lands in bit 15 of the result.
- R6: After the sixteenth receive pulse, `ee_cs` and `ee_di` are low for HOLD_CYC cycles. Then one more pulse follows with chip select still low: HIGH_CYC cycles high, then LOW_CYC cycles low.
- R7: `done` is high for exactly one cycle, the cycle after that final low phase, with `rdata` already holding the word. `busy` is high from the cycle after an accepted start until `done` and is low while `done` is high.
- R8: `rdata` changes only at a `done` strobe.
- R9: A start that arrives while `busy` is high has no effect on the pins, on the frame timing or on the word returned. A start in the `done` cycle is accepted.
- R10: During and right after reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a read when the block is idle |
| rd_addr | input | 6 | Word address, sampled with an accepted start |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle strobe: the read word is valid |
| rdata | output | 16 | Last word read |

## Verification
Every pin change is registered, so the first frame level appears in the cycle after the edge that samples start. From there each phase occupies exactly its parameter count of cycles. The done strobe follows 1 + 9·(SETUP+HIGH+LOW) + 16·(HIGH+LOW) + 2·HOLD + HIGH + LOW − 1 cycles after the first frame cycle, that is, in the cycle right after the final low phase. On an accepted start, the bench's reference expands the whole frame into a per-cycle queue of expected pin levels. At every falling clock edge it pops one entry and compares pins, busy, done and rdata, so any shift of a single cycle is caught. A behavioural EEPROM model on the pins decodes the opcode and address and returns a word computed from the address. This makes the returned value depend on the sampling point and on the bit order.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,   // outgoing bit, clock low, data settling
    ST_HIGH,    // outgoing bit, clock high
    ST_LOW,     // outgoing bit, clock low
    ST_HOLD,    // data-in parked low after the last outgoing bit
    ST_RHIGH,   // receive bit, clock high
    ST_RLOW,    // receive bit, clock low
    ST_CSOFF,   // chip select dropped
    ST_THIGH,   // trailing pulse high
    ST_TLOW     // trailing pulse low
  } rd_state_t;

  localparam int        OPC_W   = 3;
  localparam logic [2:0] OPC_READ = 3'b110;

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

  // A reload is only issued on the final cycle of a phase or from idle.
  AST_TMR_RELOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
    load |-> last); // R4

endmodule

// File: rtl/ee_rx_shift.sv
module ee_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      value <= '0;
    end else if (shift_en) begin
      value <= {value[DATA_W-2:0], bit_in};
    end
  end

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 4,
  parameter int LOW_CYC   = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int FRAME_W = OPC_W + ADDR_W;
  localparam int MAX_A   = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_B   = (LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int MAX_BIT = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int BIT_W   = $clog2(MAX_BIT);

  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_HIGH  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] L_LOW   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_OUT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] LAST_IN  = BIT_W'(DATA_W - 1);

  rd_state_t          state_q, state_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               tmr_load, tmr_last, cap, clr, done_d;
  logic [CNT_W-1:0]   tmr_val;
  logic [DATA_W-1:0]  sh_value;

  ee_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  ee_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clear(clr), .shift_en(cap), .bit_in(ee_do), .value(sh_value)
  );

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    frame_d  = frame_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    clr      = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = L_SETUP;
        bit_d = '0; frame_d = {OPC_READ, rd_addr}; clr = 1'b1;
      end
      ST_SETUP: if (tmr_last) begin
        state_d = ST_HIGH; tmr_load = 1'b1; tmr_val = L_HIGH;
      end
      ST_HIGH: if (tmr_last) begin
        state_d = ST_LOW; tmr_load = 1'b1; tmr_val = L_LOW;
      end
      ST_LOW: if (tmr_last) begin
        tmr_load = 1'b1;
        if (bit_q == LAST_OUT) begin
          state_d = ST_HOLD; tmr_val = L_HOLD; bit_d = '0;
        end else begin
          state_d = ST_SETUP; tmr_val = L_SETUP; bit_d = bit_q + 1'b1;
          frame_d = {frame_q[FRAME_W-2:0], 1'b0};
        end
      end
      ST_HOLD: if (tmr_last) begin
        state_d = ST_RHIGH; tmr_load = 1'b1; tmr_val = L_HIGH;
      end
      ST_RHIGH: if (tmr_last) begin
        state_d = ST_RLOW; tmr_load = 1'b1; tmr_val = L_LOW; cap = 1'b1;
      end
      ST_RLOW: if (tmr_last) begin
        tmr_load = 1'b1;
        if (bit_q == LAST_IN) begin
          state_d = ST_CSOFF; tmr_val = L_HOLD;
        end else begin
          state_d = ST_RHIGH; tmr_val = L_HIGH; bit_d = bit_q + 1'b1;
        end
      end
      ST_CSOFF: if (tmr_last) begin
        state_d = ST_THIGH; tmr_load = 1'b1; tmr_val = L_HIGH;
      end
      ST_THIGH: if (tmr_last) begin
        state_d = ST_TLOW; tmr_load = 1'b1; tmr_val = L_LOW;
      end
      ST_TLOW: if (tmr_last) begin
        state_d = ST_IDLE; done_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      frame_q <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
      ee_cs   <= (state_d != ST_IDLE) && (state_d != ST_CSOFF) &&
                 (state_d != ST_THIGH) && (state_d != ST_TLOW);
      ee_sk   <= (state_d == ST_HIGH) || (state_d == ST_RHIGH) || (state_d == ST_THIGH);
      ee_di   <= ((state_d == ST_SETUP) || (state_d == ST_HIGH) || (state_d == ST_LOW)) &&
                 frame_d[FRAME_W-1];
      done    <= done_d;
      if (done_d) rdata <= sh_value;
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata)); // R8
  AST_DI_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> $stable(ee_di)); // R4
  AST_CS_FALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs) |-> (!ee_sk && !ee_di)); // R6
  AST_CS_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ee_cs); // R1

endmodule

// File: tb/tb_ee_word_reader.sv
module tb_ee_word_reader;

  localparam int SETUP_CYC = 2;
  localparam int HIGH_CYC  = 4;
  localparam int LOW_CYC   = 4;
  localparam int HOLD_CYC  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        ee_do = 1'b0;
  logic        ee_cs, ee_sk, ee_di, busy, done;
  logic [15:0] rdata;

  int checks = 0;
  int failures = 0;

  ee_word_reader #(
    .ADDR_W(6), .DATA_W(16), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
    .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .busy(busy), .done(done), .rdata(rdata)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] word_of(input logic [5:0] a);
    int v;
    v = (int'(a) * 2845) ^ 16'hA5C3;
    return v[15:0];
  endfunction

  // Behavioural EEPROM: takes 9 command bits, then drives a word MSB first.
  int         m_cnt = 0;
  logic [8:0] m_cmd = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    logic [15:0] w;
    if (!ee_cs) begin
      m_cnt = 0;
      ee_do = 1'b0;
    end else begin
      if (m_cnt < 9) begin
        m_cmd = {m_cmd[7:0], ee_di};
      end else if (m_cnt < 25) begin
        w = word_of(m_cmd[5:0]);
        ee_do = (m_cmd[8:6] == 3'b110) ? w[24 - m_cnt] : 1'b0;
      end
      m_cnt = m_cnt + 1;
    end
  end

  // Reference model state: one expected {cs,sk,di} per cycle.
  logic [2:0]  exp_q[$];
  int          tag_q[$];
  bit          done_due = 1'b0;
  bit          accept_ok = 1'b1;
  bit          ign_seen = 1'b0;
  logic [15:0] pend_word = '0;
  logic [15:0] exp_rdata = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push_phase(input int n, input logic [2:0] p, input int tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_frame(input logic [5:0] a);
    logic [8:0] f;
    f = {3'b110, a};
    for (int b = 8; b >= 0; b--) begin   // R2 opcode then address, MSB first
      push_phase(SETUP_CYC, {2'b10, f[b]}, 2);
      push_phase(HIGH_CYC,  {2'b11, f[b]}, 2);
      push_phase(LOW_CYC,   {2'b10, f[b]}, 2);
    end
    push_phase(HOLD_CYC, 3'b100, 3);       // R3
    for (int b = 0; b < 16; b++) begin      // R5 receive pulses
      push_phase(HIGH_CYC, 3'b110, 5);
      push_phase(LOW_CYC,  3'b100, 5);
    end
    push_phase(HOLD_CYC, 3'b000, 6);        // R6 tail
    push_phase(HIGH_CYC, 3'b010, 6);
    push_phase(LOW_CYC,  3'b000, 6);
    pend_word = word_of(a);
    ign_seen = 1'b0;
  endtask

  task automatic tick();
    int n;
    logic [2:0] e;
    int t;
    @(negedge clk);
    n = exp_q.size();
    if (n > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({ee_cs, ee_sk, ee_di} == e, $sformatf("R%0d pins", t), {ee_cs, ee_sk, ee_di}, e);
      chk(busy == 1'b1 && done == 1'b0, "R7 busy/done in frame", {busy, done}, 2);
      if (exp_q.size() == 0) done_due = 1'b1;
    end else if (done_due) begin
      chk(done == 1'b1 && busy == 1'b0, "R7 done strobe", {busy, done}, 1);
      // R9: a start ignored during this frame must not alter the word (else R5)
      chk(rdata == pend_word, ign_seen ? "R9 word after ignored start" : "R5 word",
          rdata, pend_word);
      exp_rdata = pend_word;
      done_due = 1'b0;
    end else begin
      chk({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1 idle pins", {ee_cs, ee_sk, ee_di, busy, done}, 0);
    end
    if (!done) chk(rdata == exp_rdata, "R8 rdata held", rdata, exp_rdata);
    accept_ok = (n == 0);
  endtask

  task automatic cyc(input logic s, input logic [5:0] a);
    start = s;
    rd_addr = a;
    if (s) begin
      if (accept_ok) push_frame(a);
      else ign_seen = 1'b1;                 // R9 start while busy
    end
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() > 0 || done_due) cyc(1'b0, 6'd0);
    cyc(1'b0, 6'd0);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0) chk({ee_cs, ee_sk, ee_di, busy, done} == 5'b0 && rdata == 16'h0,
                     "R10 reset state", {ee_cs, ee_sk, ee_di, busy, done}, 0);
    end
    rst = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b0, 6'd0);   // R10 remains quiet after reset

    cyc(1'b1, 6'h00); wait_done();
    cyc(1'b1, 6'h3F); wait_done();
    cyc(1'b1, 6'h2A);                               // R9 starts arriving while busy
    for (int i = 0; i < 5; i++) cyc(1'b0, 6'd0);
    cyc(1'b1, 6'h15);
    for (int i = 0; i < 115; i++) cyc(1'b0, 6'd0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 6'h01);
    wait_done();
    cyc(1'b1, 6'h15);                               // back-to-back from done cycle
    while (exp_q.size() > 0) cyc(1'b0, 6'd0);
    cyc(1'b0, 6'd0);                                // done cycle
    cyc(1'b1, 6'h33);                               // start accepted right after done
    wait_done();
    for (int i = 0; i < 500; i++) cyc(1'b1, 6'h0C); // start held high continuously
    wait_done();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule